// File: doc/BRIEF.md
# Frame-Synchronous Window Configuration Bank

This block keeps the configuration of each display window twice: a shadow copy that the register bus writes, and an active copy that the scan-out and fetch logic use. Software may rewrite the shadow copy at any time. The active copy changes only on a vertical sync pulse, so a frame is never fetched with half-updated settings.

Each window holds eight 32-bit shadow words: buffer base, whole size, read offset, top-left corner, bottom-right corner, two alpha words and a control word. Software arms a transfer by writing an update request. On the next vsync, every armed window that is not held by its protect bit copies shadow to active. A window held back keeps its request. It transfers at the first vsync after it is released. Clearing a window's enable bit therefore stops scanning only at a vsync.

Top module: `vsb_bank`

## Requirements
- R1: After reset every shadow word, every active word, the protect bits and the update status all read zero, and `win_en_o` is zero.
- R2: A write to window address `{1'b0, win, reg}` (reg in bits [2:0], win above it) changes the shadow word read back at that address from the next cycle on. It does not change `act_cfg_o`.
- R3: `act_cfg_o` changes only on the cycle after a `vsync_i` pulse or a software reset. A vsync with no armed request leaves it unchanged.
- R4: Writing 1 to bit 0 of the control address (`{1'b1, ..., 1'b0}`) arms every window. Bit 0 read at that address is 1 while any window is still armed, and returns to 0 once all armed windows have transferred.
- R5: While protect bit w (protect address `{1'b1, ..., 1'b1}`, bit w) is set, window w's active words hold across vsync and its request stays armed. The first vsync after the bit is cleared transfers the window.
- R6: At a vsync, unprotected armed windows transfer even while another window is held.
- R7: `win_en_o[w]` mirrors bit 0 of window w's active control word (reg 7). Clearing that bit in the shadow copy keeps the window enabled until the next armed vsync.
- R8: Writing 1 to bit 1 of the control address clears both copies, all protect bits and all pending requests. A later vsync moves nothing.
- R9: A vsync in the same cycle as an update request does not consume that request. A vsync in the same cycle as a shadow write transfers the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 32 | Shadow word, protect bits or update status (combinational) |
| vsync_i | input | 1 | One-cycle vertical sync pulse |
| act_cfg_o | output | 512 | Active words; window w, reg r at bits [(w*8+r)*32 +: 32] |
| win_en_o | output | 2 | Active enable bit of each window |

## Verification
The assertions take `vsync_i` to be a single-cycle pulse that lines up with clock edges. They also take a software reset to be recognised only from a write strobe to the control address. Neither assumption covers the case where a protect write and a vsync land in the same cycle. The stimulus drives every input on the falling edge, keeps vsync high for exactly one cycle, and never overlaps a protect write with a vsync. The cases that are meant to coincide, request with vsync and shadow write with vsync, are driven together on purpose.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  localparam int unsigned NREG     = 8;
  localparam int unsigned REG_BITS = 3;

  typedef enum logic [REG_BITS-1:0] {
    REG_BASE   = 3'd0,
    REG_SIZE   = 3'd1,
    REG_OFS    = 3'd2,
    REG_TL     = 3'd3,
    REG_BR     = 3'd4,
    REG_ALPHA0 = 3'd5,
    REG_ALPHA1 = 3'd6,
    REG_CTRL   = 3'd7
  } win_reg_e;

  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned GLB_UPD_BIT = 0;
  localparam int unsigned GLB_RST_BIT = 1;
endpackage

// File: rtl/vsb_dec.sv
module vsb_dec
  import vsb_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned WIN_BITS = 1,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [1:0]          glb_bits_i,
  output logic [NUM_WIN-1:0]  win_we_o,
  output logic [REG_BITS-1:0] reg_idx_o,
  output logic                upd_set_o,
  output logic                swrst_o,
  output logic                prot_we_o
);
  logic                is_glb;
  logic [WIN_BITS-1:0] win_sel;

  always_comb begin
    is_glb    = wr_addr_i[ADDR_W-1];
    win_sel   = wr_addr_i[REG_BITS +: WIN_BITS];
    reg_idx_o = wr_addr_i[REG_BITS-1:0];
    for (int w = 0; w < NUM_WIN; w++)
      win_we_o[w] = wr_en_i && !is_glb && (win_sel == WIN_BITS'(w));
    upd_set_o = wr_en_i && is_glb && !wr_addr_i[0] && glb_bits_i[GLB_UPD_BIT];
    swrst_o   = wr_en_i && is_glb && !wr_addr_i[0] && glb_bits_i[GLB_RST_BIT];
    prot_we_o = wr_en_i && is_glb &&  wr_addr_i[0];
  end
endmodule

// File: rtl/vsb_win.sv
module vsb_win
  import vsb_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                swrst_i,
  input  logic                we_i,
  input  logic [REG_BITS-1:0] idx_i,
  input  logic [DW-1:0]       data_i,
  input  logic                xfer_i,
  output logic [NREG*DW-1:0]  shadow_o,
  output logic [NREG*DW-1:0]  active_o
);
  logic [DW-1:0] sh_q  [NREG];
  logic [DW-1:0] act_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) begin
        sh_q[r]  <= '0;
        act_q[r] <= '0;
      end
    end else if (swrst_i) begin
      for (int r = 0; r < NREG; r++) begin
        sh_q[r]  <= '0;
        act_q[r] <= '0;
      end
    end else begin
      // active takes the pre-write shadow when both happen together
      if (xfer_i)
        for (int r = 0; r < NREG; r++) act_q[r] <= sh_q[r];
      if (we_i) sh_q[idx_i] <= data_i;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_flat
    assign shadow_o[r*DW +: DW] = sh_q[r];
    assign active_o[r*DW +: DW] = act_q[r];
  end
endmodule

// File: rtl/vsb_sync.sv
module vsb_sync #(
  parameter int unsigned NUM_WIN = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               swrst_i,
  input  logic               upd_set_i,
  input  logic               prot_we_i,
  input  logic [NUM_WIN-1:0] prot_data_i,
  input  logic               vsync_i,
  output logic [NUM_WIN-1:0] prot_o,
  output logic [NUM_WIN-1:0] pend_o,
  output logic [NUM_WIN-1:0] xfer_o
);
  logic [NUM_WIN-1:0] prot_q, pend_q;

  assign xfer_o = {NUM_WIN{vsync_i}} & pend_q & ~prot_q;
  assign prot_o = prot_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= '0;
      pend_q <= '0;
    end else if (swrst_i) begin
      prot_q <= '0;
      pend_q <= '0;
    end else begin
      if (prot_we_i) prot_q <= prot_data_i;
      // a fresh request survives a coincident vsync
      pend_q <= (pend_q & ~xfer_o) | {NUM_WIN{upd_set_i}};
    end
  end
endmodule

// File: rtl/vsb_bank.sv
module vsb_bank
  import vsb_pkg::*;
#(
  parameter  int unsigned NUM_WIN  = 2,
  parameter  int unsigned DW       = 32,
  localparam int unsigned WIN_BITS = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int unsigned ADDR_W   = 1 + WIN_BITS + REG_BITS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [DW-1:0]              rd_data_o,
  input  logic                       vsync_i,
  output logic [NUM_WIN*NREG*DW-1:0] act_cfg_o,
  output logic [NUM_WIN-1:0]         win_en_o
);
  logic [NUM_WIN-1:0]         win_we, prot_q, pend_q, xfer;
  logic [REG_BITS-1:0]        reg_idx;
  logic                       upd_set, swrst, prot_we;
  logic [NUM_WIN*NREG*DW-1:0] sh_all;

  vsb_dec #(.NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS), .ADDR_W(ADDR_W)) u_dec (
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .glb_bits_i (wr_data_i[1:0]),
    .win_we_o   (win_we),
    .reg_idx_o  (reg_idx),
    .upd_set_o  (upd_set),
    .swrst_o    (swrst),
    .prot_we_o  (prot_we)
  );

  vsb_sync #(.NUM_WIN(NUM_WIN)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .swrst_i     (swrst),
    .upd_set_i   (upd_set),
    .prot_we_i   (prot_we),
    .prot_data_i (wr_data_i[NUM_WIN-1:0]),
    .vsync_i     (vsync_i),
    .prot_o      (prot_q),
    .pend_o      (pend_q),
    .xfer_o      (xfer)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    vsb_win #(.DW(DW)) u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .swrst_i  (swrst),
      .we_i     (win_we[w]),
      .idx_i    (reg_idx),
      .data_i   (wr_data_i),
      .xfer_i   (xfer[w]),
      .shadow_o (sh_all[w*NREG*DW +: NREG*DW]),
      .active_o (act_cfg_o[w*NREG*DW +: NREG*DW])
    );
    assign win_en_o[w] = act_cfg_o[(w*NREG + int'(REG_CTRL))*DW + CTRL_EN_BIT];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i[ADDR_W-1]) begin
      if (rd_addr_i[0]) rd_data_o[NUM_WIN-1:0] = prot_q;
      else              rd_data_o[GLB_UPD_BIT] = |pend_q;
    end else begin
      for (int w = 0; w < NUM_WIN; w++)
        for (int r = 0; r < NREG; r++)
          if (rd_addr_i[ADDR_W-2:0] == (ADDR_W-1)'(w*NREG + r))
            rd_data_o = sh_all[(w*NREG + r)*DW +: DW];
    end
  end
endmodule

// File: rtl/vsb_bank_chk.sv
module vsb_bank_chk
  import vsb_pkg::*;
#(
  parameter  int unsigned NUM_WIN  = 2,
  parameter  int unsigned DW       = 32,
  localparam int unsigned WIN_BITS = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int unsigned ADDR_W   = 1 + WIN_BITS + REG_BITS
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic [ADDR_W-1:0]          wr_addr_i,
  input logic [DW-1:0]              wr_data_i,
  input logic                       vsync_i,
  input logic [NUM_WIN*NREG*DW-1:0] act_cfg_o,
  input logic [NUM_WIN-1:0]         win_en_o,
  input logic [NUM_WIN-1:0]         prot_q,
  input logic [NUM_WIN*NREG*DW-1:0] sh_all
);
  logic swrst_c;
  assign swrst_c = wr_en_i && wr_addr_i[ADDR_W-1] && !wr_addr_i[0] && wr_data_i[GLB_RST_BIT];

  // R3
  act_only_at_vsync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(vsync_i) && !$past(swrst_c)) |-> $stable(act_cfg_o));

  // R7
  en_only_at_vsync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(vsync_i) && !$past(swrst_c)) |-> $stable(win_en_o));

  // R8
  swrst_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_c |=> (act_cfg_o == '0 && sh_all == '0 && prot_q == '0));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
    // R5
    prot_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(prot_q[w]) && !$past(swrst_c)) |-> $stable(act_cfg_o[w*NREG*DW +: NREG*DW]));
    for (genvar r = 0; r < NREG; r++) begin : g_r
      localparam logic [ADDR_W-1:0] WA = ADDR_W'(w*NREG + r);
      // R2
      shadow_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == WA) |=> sh_all[(w*NREG + r)*DW +: DW] == $past(wr_data_i));
    end
  end
endmodule

bind vsb_bank vsb_bank_chk #(.NUM_WIN(NUM_WIN), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .vsync_i   (vsync_i),
  .act_cfg_o (act_cfg_o),
  .win_en_o  (win_en_o),
  .prot_q    (prot_q),
  .sh_all    (sh_all)
);

// File: tb/vsb_bank_bench.sv
module vsb_bank_bench;
  localparam int NW = 2;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam logic [AW-1:0] CTRL_A = 5'b10000;
  localparam logic [AW-1:0] PROT_A = 5'b10001;

  typedef struct packed {
    logic [3:0]  w;
    logic [3:0]  r;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 4'd0, 32'h1000_0000},
    '{4'd0, 4'd1, 32'h0300_0400},
    '{4'd0, 4'd3, 32'h0010_0020},
    '{4'd0, 4'd7, 32'h0000_0003},
    '{4'd1, 4'd0, 32'h2000_0040},
    '{4'd1, 4'd4, 32'h0040_0080},
    '{4'd1, 4'd5, 32'h00ff_ffff},
    '{4'd1, 4'd7, 32'h0000_0021}
  };

  logic           clk = 0;
  logic           rst_n = 0;
  logic           wr_en = 0;
  logic [AW-1:0]  wr_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [DW-1:0]  rd_data;
  logic           vsync = 0;
  logic [NW*8*DW-1:0] act_cfg;
  logic [NW-1:0]  win_en;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vsb_bank u_vsb_bank (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
    .wr_data_i (wr_data), .rd_addr_i (rd_addr), .rd_data_o (rd_data),
    .vsync_i (vsync), .act_cfg_o (act_cfg), .win_en_o (win_en)
  );

  function automatic logic [AW-1:0] wa(int w, int r);
    return AW'(w*8 + r);
  endfunction

  function automatic logic [31:0] act(int w, int r);
    return act_cfg[(w*8 + r)*32 +: 32];
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // all drives on the falling edge; state is observed on the next falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic vs);
    wr_en = 1; wr_addr = a; wr_data = d; vsync = vs;
    @(negedge clk);
    wr_en = 0; vsync = 0;
  endtask

  task automatic pulse_vsync();
    vsync = 1;
    @(negedge clk);
    vsync = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(wa(0, 0), d); check("R1 shadow w0", d, 0);
    rd(wa(1, 7), d); check("R1 shadow w1 ctrl", d, 0);
    rd(CTRL_A, d);   check("R1 pending", d, 0);
    rd(PROT_A, d);   check("R1 protect", d, 0);
    check("R1 active zero", 32'(act_cfg != '0), 0);
    check("R1 win_en", 32'(win_en), 0);

    // R2 table walk: shadow updates, active does not
    for (int i = 0; i < NV; i++) begin
      wr(wa(VEC[i].w, VEC[i].r), VEC[i].d, 1'b0);
      rd(wa(VEC[i].w, VEC[i].r), d);
      check("R2 shadow readback", d, VEC[i].d);
      check("R2 active untouched", act(VEC[i].w, VEC[i].r), 0);
    end

    // R3 vsync without request
    pulse_vsync();
    check("R3 no request no copy", 32'(act_cfg != '0), 0);

    // R4 arm, then transfer
    wr(CTRL_A, 32'h1, 1'b0);
    rd(CTRL_A, d); check("R4 pending set", d, 1);
    check("R3 still idle before vsync", 32'(act_cfg != '0), 0);
    pulse_vsync();
    for (int i = 0; i < NV; i++)
      check("R3 active copied", act(VEC[i].w, VEC[i].r), VEC[i].d);
    rd(CTRL_A, d); check("R4 pending cleared", d, 0);
    check("R7 both enabled", 32'(win_en), 3);

    // R7 disable window 1 waits for vsync
    wr(wa(1, 7), 32'h0, 1'b0);
    wr(CTRL_A, 32'h1, 1'b0);
    repeat (3) @(negedge clk);
    check("R7 still scanning", 32'(win_en), 3);
    pulse_vsync();
    check("R7 disabled at vsync", 32'(win_en), 1);

    // R5/R6 protect window 0
    wr(PROT_A, 32'h1, 1'b0);
    rd(PROT_A, d); check("R5 protect readback", d, 1);
    wr(wa(0, 0), 32'hAAAA_0000, 1'b0);
    wr(wa(1, 0), 32'hBBBB_0000, 1'b0);
    wr(CTRL_A, 32'h1, 1'b0);
    pulse_vsync();
    check("R6 unprotected copied", act(1, 0), 32'hBBBB_0000);
    check("R5 protected held", act(0, 0), 32'h1000_0000);
    rd(CTRL_A, d); check("R5 request kept", d, 1);
    pulse_vsync();
    check("R5 still held", act(0, 0), 32'h1000_0000);
    wr(PROT_A, 32'h0, 1'b0);
    check("R5 no copy before vsync", act(0, 0), 32'h1000_0000);
    pulse_vsync();
    check("R5 copied after release", act(0, 0), 32'hAAAA_0000);
    rd(CTRL_A, d); check("R4 all done", d, 0);

    // R9 request coincident with vsync
    wr(wa(1, 0), 32'hCCCC_0000, 1'b0);
    wr(CTRL_A, 32'h1, 1'b1);
    check("R9 request not consumed", act(1, 0), 32'hBBBB_0000);
    rd(CTRL_A, d); check("R9 still pending", d, 1);
    pulse_vsync();
    check("R9 next vsync copies", act(1, 0), 32'hCCCC_0000);

    // R9 shadow write coincident with vsync
    wr(wa(1, 0), 32'hEEEE_0000, 1'b0);
    wr(CTRL_A, 32'h1, 1'b0);
    wr(wa(1, 0), 32'hDDDD_0000, 1'b1);
    check("R9 old shadow copied", act(1, 0), 32'hEEEE_0000);
    rd(wa(1, 0), d); check("R9 new shadow kept", d, 32'hDDDD_0000);

    // R8 software reset
    wr(PROT_A, 32'h2, 1'b0);
    wr(CTRL_A, 32'h1, 1'b0);
    wr(CTRL_A, 32'h2, 1'b0);
    check("R8 active cleared", 32'(act_cfg != '0), 0);
    check("R8 win_en cleared", 32'(win_en), 0);
    rd(PROT_A, d);   check("R8 protect cleared", d, 0);
    rd(CTRL_A, d);   check("R8 pending cleared", d, 0);
    rd(wa(1, 0), d); check("R8 shadow cleared", d, 0);
    wr(wa(0, 1), 32'h1234_5678, 1'b0);
    pulse_vsync();
    check("R8 no stale transfer", act(0, 1), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule